// File: doc/BRIEF.md
# Bus-Master Acquisition Handshake Controller

This controller lives inside a device that wants to become master of a shared 68000-style bus. When local logic asks to start a transfer, it pulls the shared bus-request line low and waits for the current owner to answer with a bus grant. A grant only means that release is imminent. The controller then waits until the current owner has actually left the bus, with the address strobe and the data acknowledge both negated. Only then does it pull bus-grant-acknowledge low and tell the local transfer engine that it owns the bus.

The local engine signals the end of its work with a one-cycle done pulse. The controller then lets go of both shared lines at once. It makes no new request until it has seen the grant withdrawn. The shared lines are wire-ORed, open-drain signals. The block therefore exposes only pull-low enables and never drives a line high. The grant, strobe and acknowledge pins are asynchronous to the local clock and pass through a synchronizer of configurable depth before the state machine sees them.

Top module: `bus_master_handshake`

## Requirements
- R1: While reset is applied and on the first cycle after it, `br_pull_o`, `bgack_pull_o` and `owned_o` are all low.
- R2: In the idle state, a local request (`xfer_req_i` high at a clock edge) sets `br_pull_o` high at that same edge.
- R3: The pins `bg_n_i`, `as_n_i` and `dtack_n_i` reach the state machine through SYNC_STAGES (default 2) flops. A pin change applied before edge k can change an output no earlier than edge k+SYNC_STAGES.
- R4: `bgack_pull_o` rises only after a grant (`bg_n_i` low) has been seen while requesting, and only while the synchronized `as_n_i` and `dtack_n_i` are both high. It stays low for as long as either of them is low.
- R5: `owned_o` is high exactly while `bgack_pull_o` is high.
- R6: An `xfer_done_i` pulse while owning clears `br_pull_o`, `bgack_pull_o` and `owned_o` at the next edge.
- R7: After a release, `br_pull_o` stays low even if `xfer_req_i` is still high, until the synchronized grant has been seen negated (`bg_n_i` high). After that a request is accepted again.
- R8: If `xfer_req_i` drops while requesting and before a grant is seen, `br_pull_o` falls at the next edge and `bgack_pull_o` never rises.
- R9: `br_pull_o` stays high continuously from the request until the release, including the whole time the bus is owned.
- R10: `xfer_done_i` has no effect unless the bus is owned. Outside ownership all outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req_i | input | 1 | Local request to acquire the bus (level) |
| xfer_done_i | input | 1 | One-cycle pulse: local transfer finished |
| bg_n_i | input | 1 | Bus grant from current owner, active low, asynchronous |
| as_n_i | input | 1 | Shared address strobe, active low, asynchronous |
| dtack_n_i | input | 1 | Shared data acknowledge, active low, asynchronous |
| br_pull_o | output | 1 | Enable to pull the shared bus-request line low |
| bgack_pull_o | output | 1 | Enable to pull the shared grant-acknowledge line low |
| owned_o | output | 1 | Bus owned; gates the local transfer engine |

## Verification
Embedded assertions check the following on every cycle: acknowledge rises only from the wait state with both strobe and acknowledge seen idle, acknowledge always comes with a request, ownership matches acknowledge, a done pulse releases both lines, and a withdrawn request drops the request line. The bench's scenarios are needed to show the exact synchronizer latency, the refusal to re-request while the old grant lingers, and the absence of any effect from stray done pulses. A behavioural reference model with queue-based input delays is compared against all three outputs on every clock.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_REQUEST   = 3'd1,
        ST_WAIT_FREE = 3'd2,
        ST_OWN       = 3'd3,
        ST_RELEASE   = 3'd4
    } bm_state_e;

    typedef struct packed {
        bm_state_e state;
        logic      br;
        logic      bgack;
        logic      owned;
    } bm_regs_t;

    localparam int unsigned BUS_IN_W = 3;
    localparam int unsigned IDX_BG    = 2;
    localparam int unsigned IDX_AS    = 1;
    localparam int unsigned IDX_DTACK = 0;

endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
    parameter int unsigned WIDTH     = 3,
    parameter int unsigned STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/bm_fsm.sv
module bm_fsm
    import bm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic done_i,
    input  logic grant_i,
    input  logic as_idle_i,
    input  logic dtack_idle_i,
    output logic br_o,
    output logic bgack_o,
    output logic owned_o
);
    bm_regs_t r_d, r_q;
    logic     bus_free;

    assign bus_free = as_idle_i && dtack_idle_i;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE:      if (req_i)       r_d.state = ST_REQUEST;
            ST_REQUEST: begin
                if (!req_i)                r_d.state = ST_IDLE;
                else if (grant_i)          r_d.state = ST_WAIT_FREE;
            end
            ST_WAIT_FREE: if (bus_free)    r_d.state = ST_OWN;
            ST_OWN:       if (done_i)      r_d.state = ST_RELEASE;
            ST_RELEASE:   if (!grant_i)    r_d.state = ST_IDLE;
            default:                       r_d.state = ST_IDLE;
        endcase
        r_d.br    = (r_d.state == ST_REQUEST) || (r_d.state == ST_WAIT_FREE)
                 || (r_d.state == ST_OWN);
        r_d.bgack = (r_d.state == ST_OWN);
        r_d.owned = (r_d.state == ST_OWN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, br: 1'b0, bgack: 1'b0, owned: 1'b0};
        else        r_q <= r_d;
    end

    assign br_o    = r_q.br;
    assign bgack_o = r_q.bgack;
    assign owned_o = r_q.owned;

    p_ack_after_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.bgack) |-> $past(bus_free && r_q.state == ST_WAIT_FREE));

    p_ack_with_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bgack |-> r_q.br);

    p_owned_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.owned == r_q.bgack);

    p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.bgack && done_i) |=> (!r_q.br && !r_q.bgack));

    p_withdraw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_REQUEST && !req_i) |=> (!r_q.br && !r_q.bgack));

    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RELEASE && grant_i) |=> !r_q.br);
endmodule

// File: rtl/bus_master_handshake.sv
module bus_master_handshake
    import bm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req_i,
    input  logic xfer_done_i,
    input  logic bg_n_i,
    input  logic as_n_i,
    input  logic dtack_n_i,
    output logic br_pull_o,
    output logic bgack_pull_o,
    output logic owned_o
);
    logic [BUS_IN_W-1:0] pins_raw;
    logic [BUS_IN_W-1:0] pins_sync;

    always_comb begin
        pins_raw            = '1;
        pins_raw[IDX_BG]    = bg_n_i;
        pins_raw[IDX_AS]    = as_n_i;
        pins_raw[IDX_DTACK] = dtack_n_i;
    end

    bm_sync #(
        .WIDTH  (BUS_IN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({BUS_IN_W{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pins_raw),
        .sync_o (pins_sync)
    );

    bm_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (xfer_req_i),
        .done_i      (xfer_done_i),
        .grant_i     (!pins_sync[IDX_BG]),
        .as_idle_i   (pins_sync[IDX_AS]),
        .dtack_idle_i(pins_sync[IDX_DTACK]),
        .br_o        (br_pull_o),
        .bgack_o     (bgack_pull_o),
        .owned_o     (owned_o)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!br_pull_o && !bgack_pull_o && !owned_o));
endmodule

// File: tb/tb_bus_master_handshake.sv
module tb_bus_master_handshake;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, done = 1'b0;
    logic bg_n = 1'b1, as_n = 1'b1, dtack_n = 1'b1;
    logic br, bgack, owned;

    int tests = 0, fails = 0;
    bit finished = 0;

    bus_master_handshake #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .xfer_req_i(req), .xfer_done_i(done),
        .bg_n_i(bg_n), .as_n_i(as_n), .dtack_n_i(dtack_n),
        .br_pull_o(br), .bgack_pull_o(bgack), .owned_o(owned));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: 0 idle, 1 asking, 2 granted/waiting, 3 owning, 4 letting go
    int  m_st;
    bit  q_bg[$], q_as[$], q_dt[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0;
            q_bg = {}; q_as = {}; q_dt = {};
            repeat (SYNC) begin q_bg.push_back(1); q_as.push_back(1); q_dt.push_back(1); end
        end else begin
            bit g_n, a_n, d_n;
            g_n = q_bg.pop_front(); q_bg.push_back(bg_n);
            a_n = q_as.pop_front(); q_as.push_back(as_n);
            d_n = q_dt.pop_front(); q_dt.push_back(dtack_n);
            case (m_st)
                0: if (req) m_st = 1;
                1: if (!req) m_st = 0; else if (!g_n) m_st = 2;
                2: if (a_n && d_n) m_st = 3;
                3: if (done) m_st = 4;
                4: if (g_n) m_st = 0;
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R9 model br",    br,    (m_st >= 1 && m_st <= 3));
            chk("R4 model bgack", bgack, (m_st == 3));
            chk("R5 model owned", owned, (m_st == 3));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        tick(WATCHDOG);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        chk("R1 br in reset", br, 1'b0);
        chk("R1 bgack in reset", bgack, 1'b0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 br after reset", br, 1'b0);
        chk("R1 owned after reset", owned, 1'b0);

        // Full acquisition with the old owner still on the bus
        req = 1'b1;
        tick(1);
        chk("R2 request asserted", br, 1'b1);
        bg_n = 1'b0; as_n = 1'b0; dtack_n = 1'b0;
        tick(6);
        chk("R4 busy strobe blocks ack", bgack, 1'b0);
        chk("R9 request held", br, 1'b1);
        as_n = 1'b1;
        tick(5);
        chk("R4 dtack low blocks ack", bgack, 1'b0);
        dtack_n = 1'b1;
        tick(SYNC);
        chk("R3 no ack before sync latency", bgack, 1'b0);
        tick(1);
        chk("R3 ack after sync latency", bgack, 1'b1);
        chk("R5 owned with ack", owned, 1'b1);
        tick(3);
        chk("R9 request held while owning", br, 1'b1);
        done = 1'b1;
        tick(1);
        done = 1'b0;
        chk("R6 br released", br, 1'b0);
        chk("R6 bgack released", bgack, 1'b0);
        chk("R6 owned cleared", owned, 1'b0);

        // Grant lingers while the local request stays high
        tick(6);
        chk("R7 no re-request under old grant", br, 1'b0);
        bg_n = 1'b1;
        tick(SYNC + 2);
        chk("R7 re-request after grant negated", br, 1'b1);

        // Withdraw before any grant
        req = 1'b0;
        tick(1);
        chk("R8 withdraw drops request", br, 1'b0);
        tick(4);
        chk("R8 no ack after withdraw", bgack, 1'b0);

        // Stray done pulses outside ownership
        done = 1'b1;
        tick(1);
        done = 1'b0;
        tick(3);
        chk("R10 idle done ignored br", br, 1'b0);
        chk("R10 idle done ignored owned", owned, 1'b0);
        req = 1'b1;
        tick(1);
        done = 1'b1;
        tick(1);
        done = 1'b0;
        chk("R10 done while asking keeps request", br, 1'b1);

        // Grant arrives with the bus already idle
        bg_n = 1'b0;
        tick(SYNC + 2);
        chk("R4 ack with free bus", bgack, 1'b1);
        req = 1'b0;
        done = 1'b1;
        tick(1);
        done = 1'b0;
        bg_n = 1'b1;
        chk("R6 second release", br, 1'b0);
        tick(SYNC + 3);
        chk("R7 idle after grant negated", br, 1'b0);
        finish_run();
    end
endmodule